// File: doc/BRIEF.md
# Configurable Bridge Gate Command Logic

This block is the synchronous decision logic in front of four external gate drivers. Those drivers switch two bridge legs, A and B. Each leg has one high-side gate and one low-side gate. The block samples a set of logic-level control inputs and works out the wanted on/off state of every gate. It then applies a break-before-make interval on each leg before a new state reaches the gates. Its outputs are registered enables that can go straight to the level shifters.

A mode input decides how the remaining control pins are read. In full-bridge mode the pins are direction, enable, PWM, quick-stop and brake, and they drive the two legs as diagonal pairs. This supports both sign/magnitude and anti-phase PWM. In dual half-bridge mode the same pins become a command and an enable for each leg, and the two legs run independently. An undervoltage flag and a per-leg overcurrent inhibit, supplied by other blocks, take priority over the normal commands. From highest to lowest, the priority is undervoltage, then disable, then overcurrent, then brake, then normal operation.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: Full-bridge mode (`mode_full`=1), enabled, no inhibit, no brake, `qs_inb`=0. `dir_ina`=1 gives leg A high = `pwm_enb` and leg B low = `pwm_enb`, with leg A low and leg B high off. `dir_ina`=0 is the mirror: leg B high = `pwm_enb` and leg A low = `pwm_enb`, with the other two gates off.
- R2: Full-bridge mode with `qs_inb`=1 keeps the high-side gate of the active diagonal steadily on, and only that diagonal's low-side gate follows `pwm_enb`.
- R3: In full-bridge mode, `brake`=1 turns both low-side gates on and both high-side gates off. It ranks below enable and overcurrent. In half-bridge mode `brake` has no effect on any gate.
- R4: In half-bridge mode, leg A uses `dir_ina` as its command and `en_ena` as its enable. Leg B uses `qs_inb` as its command and `pwm_enb` as its enable. An enabled leg with command 1 drives its high gate only, and with command 0 drives its low gate only. A disabled leg is fully off, and the other leg is not affected.
- R5: In full-bridge mode, `en_ena`=0 turns all four gates off.
- R6: An overcurrent inhibit (`oc_inhibit` bit 0 = leg A, bit 1 = leg B) turns all four gates off in full-bridge mode. In half-bridge mode it turns off only its own leg. It ranks above brake.
- R7: `uv_fault`=1 turns all four gates off in every mode, above every other input.
- R8: When a leg's commanded state changes, both gates of that leg are off for exactly `DEAD_CYC` cycles, starting from the clock edge that samples the change. The new state appears on the next edge. A leg whose command did not change keeps its gates unchanged.
- R9: A further change to a leg's command while its interval is still running restarts the full `DEAD_CYC` interval from that change.
- R10: An anti-phase edge (`dir_ina` toggling with `pwm_enb`=1) passes through the interval on both legs.
- R11: During reset, and after reset until a command is applied, all gates are off.
- R12: The high-side and low-side gates of one leg are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_full | input | 1 | 1 selects full H-bridge, 0 selects two half-bridges |
| dir_ina | input | 1 | Direction (full mode) or leg A command (half mode) |
| en_ena | input | 1 | Bridge enable (full) or leg A enable (half) |
| pwm_enb | input | 1 | PWM (full) or leg B enable (half) |
| qs_inb | input | 1 | Quick-stop select (full) or leg B command (half) |
| brake | input | 1 | Low-side brake request (full mode only) |
| oc_inhibit | input | 2 | Overcurrent inhibit per leg, bit 0 leg A |
| uv_fault | input | 1 | Undervoltage flag |
| gate_hi | output | 2 | High-side gate enables, bit 0 leg A |
| gate_lo | output | 2 | Low-side gate enables, bit 0 leg A |

## Verification
Each leg holds three pieces of state: the last command it accepted, a countdown and the registered gate pair. A fault in any of them shows at the gate ports within `DEAD_CYC`+1 cycles of a command change. A wrong countdown makes a gate turn on one cycle early or late. A stale held command either blanks a leg that should be untouched or skips the interval. A mis-decoded pin mapping gives a wrong steady gate pattern for that input combination. The bench walks every one of the 512 input combinations in two different orders. It checks every cycle of every interval, so a wrong transition is caught in the first cycle it shows.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_cmd_t;

  localparam int unsigned NUM_LEGS = 2;
  localparam int unsigned LEG_A    = 0;
  localparam int unsigned LEG_B    = 1;

  localparam leg_cmd_t LEG_OFF = '{hi: 1'b0, lo: 1'b0};
endpackage

// File: rtl/bgc_full_decode.sv
module bgc_full_decode
  import bgc_pkg::*;
(
  input  logic                      dir,
  input  logic                      en,
  input  logic                      pwm,
  input  logic                      qs,
  input  logic                      brake,
  input  logic [NUM_LEGS-1:0]       oc,
  input  logic                      uv,
  output leg_cmd_t [NUM_LEGS-1:0]   cmd
);
  logic top_on;

  // Quick-stop high keeps the active top device on; low makes it follow PWM.
  assign top_on = qs | pwm;

  always_comb begin
    cmd = '0;
    if (uv || !en || (|oc)) begin
      cmd = '0;
    end else if (brake) begin
      cmd[LEG_A].lo = 1'b1;
      cmd[LEG_B].lo = 1'b1;
    end else if (dir) begin
      cmd[LEG_A].hi = top_on;
      cmd[LEG_B].lo = pwm;
    end else begin
      cmd[LEG_B].hi = top_on;
      cmd[LEG_A].lo = pwm;
    end
  end
endmodule

// File: rtl/bgc_half_decode.sv
module bgc_half_decode
  import bgc_pkg::*;
(
  input  logic [NUM_LEGS-1:0]       leg_in,
  input  logic [NUM_LEGS-1:0]       leg_en,
  input  logic [NUM_LEGS-1:0]       oc,
  input  logic                      uv,
  output leg_cmd_t [NUM_LEGS-1:0]   cmd
);
  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    logic allowed;
    assign allowed = !uv && leg_en[g] && !oc[g];

    always_comb begin
      cmd[g] = LEG_OFF;
      if (allowed) begin
        cmd[g].hi = leg_in[g];
        cmd[g].lo = !leg_in[g];
      end
    end
  end
endmodule

// File: rtl/bgc_leg_bbm.sv
module bgc_leg_bbm
  import bgc_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 25
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_cmd_t req,
  output leg_cmd_t gate
);
  localparam int unsigned CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);

  leg_cmd_t        held_q, held_d;
  leg_cmd_t        gate_q, gate_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            changed;
  logic            busy;
  logic            held_en;
  logic            cnt_en;

  assign changed = (req != held_q);
  assign busy    = (cnt_q != '0);
  assign held_en = changed;
  assign cnt_en  = changed || busy;

  always_comb begin
    held_d = held_q;
    cnt_d  = cnt_q;
    gate_d = held_q;
    if (changed) begin
      held_d = req;
      cnt_d  = LOAD;
      gate_d = LEG_OFF;
    end else if (busy) begin
      cnt_d  = cnt_q - 1'b1;
      gate_d = LEG_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= LEG_OFF;
      cnt_q  <= '0;
      gate_q <= LEG_OFF;
    end else begin
      if (held_en) held_q <= held_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      gate_q <= gate_d;
    end
  end

  assign gate = gate_q;

  assert_no_shoot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q.hi && gate_q.lo));

  assert_change_blanks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req != held_q) |=> (gate_q == LEG_OFF));

  assert_on_from_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != LEG_OFF) |=> (gate_q == LEG_OFF || gate_q == $past(gate_q)));
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
  import bgc_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_full,
  input  logic       dir_ina,
  input  logic       en_ena,
  input  logic       pwm_enb,
  input  logic       qs_inb,
  input  logic       brake,
  input  logic [1:0] oc_inhibit,
  input  logic       uv_fault,
  output logic [1:0] gate_hi,
  output logic [1:0] gate_lo
);
  leg_cmd_t [NUM_LEGS-1:0] full_cmd;
  leg_cmd_t [NUM_LEGS-1:0] half_cmd;
  leg_cmd_t [NUM_LEGS-1:0] sel_cmd;
  leg_cmd_t [NUM_LEGS-1:0] leg_gate;

  bgc_full_decode u_full (
    .dir   (dir_ina),
    .en    (en_ena),
    .pwm   (pwm_enb),
    .qs    (qs_inb),
    .brake (brake),
    .oc    (oc_inhibit),
    .uv    (uv_fault),
    .cmd   (full_cmd)
  );

  bgc_half_decode u_half (
    .leg_in ({qs_inb, dir_ina}),
    .leg_en ({pwm_enb, en_ena}),
    .oc     (oc_inhibit),
    .uv     (uv_fault),
    .cmd    (half_cmd)
  );

  assign sel_cmd = mode_full ? full_cmd : half_cmd;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    bgc_leg_bbm #(.DEAD_CYC(DEAD_CYC)) u_bbm (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (sel_cmd[g]),
      .gate  (leg_gate[g])
    );
    assign gate_hi[g] = leg_gate[g].hi;
    assign gate_lo[g] = leg_gate[g].lo;
  end

  assert_uv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault |=> (gate_hi == 2'b00 && gate_lo == 2'b00));

  assert_disable_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_full && !en_ena) |=> (gate_hi == 2'b00 && gate_lo == 2'b00));

  assert_full_oc_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_full && (|oc_inhibit)) |=> (gate_hi == 2'b00 && gate_lo == 2'b00));

  assert_half_en_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_full && !en_ena) |=> (gate_hi[0] == 1'b0 && gate_lo[0] == 1'b0));
endmodule

// File: tb/test_bridge_gate_ctrl.sv
`timescale 1ns/1ps
module test_bridge_gate_ctrl;
  localparam int unsigned DEAD = 4;

  logic       clk;
  logic       rst_n;
  logic       mode_full, dir_ina, en_ena, pwm_enb, qs_inb, brake, uv_fault;
  logic [1:0] oc_inhibit;
  logic [1:0] gate_hi, gate_lo;

  int tests;
  int failed;
  bit finished;
  logic [8:0] cur;

  bridge_gate_ctrl #(.DEAD_CYC(DEAD)) i_bridge_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_full(mode_full), .dir_ina(dir_ina),
    .en_ena(en_ena), .pwm_enb(pwm_enb), .qs_inb(qs_inb), .brake(brake),
    .oc_inhibit(oc_inhibit), .uv_fault(uv_fault),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stimulus bits: 0 mode, 1 dir/ina, 2 en/ena, 3 pwm/enb, 4 qs/inb, 5 brake, 7:6 oc, 8 uv
  function automatic logic [3:0] expect_gates(input logic [8:0] s);
    logic a_hi, a_lo, b_hi, b_lo;
    a_hi = 0; a_lo = 0; b_hi = 0; b_lo = 0;
    if (!s[8]) begin
      if (s[0]) begin
        if (s[2] && s[7:6] == 2'b00) begin
          if (s[5]) begin a_lo = 1; b_lo = 1; end
          else if (s[1]) begin a_hi = s[4] ? 1'b1 : s[3]; b_lo = s[3]; end
          else begin b_hi = s[4] ? 1'b1 : s[3]; a_lo = s[3]; end
        end
      end else begin
        if (s[2] && !s[6]) begin a_hi = s[1]; a_lo = !s[1]; end
        if (s[3] && !s[7]) begin b_hi = s[4]; b_lo = !s[4]; end
      end
    end
    return {b_hi, b_lo, a_hi, a_lo};
  endfunction

  function automatic string tag_of(input logic [8:0] s);
    if (s[8]) return "R7";
    if (s[0] && !s[2]) return "R5";
    if (s[7:6] != 2'b00) return "R6";
    if (s[5]) return "R3";
    if (!s[0]) return "R4";
    if (s[4]) return "R2";
    return "R1";
  endfunction

  task automatic drive(input logic [8:0] s);
    mode_full = s[0]; dir_ina = s[1]; en_ena = s[2]; pwm_enb = s[3];
    qs_inb = s[4]; brake = s[5]; oc_inhibit = s[7:6]; uv_fault = s[8];
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] expv);
    tests++;
    if (act !== expv) begin
      failed++;
      $display("FAIL %s: gates {hiB,loB,hiA,loA} actual %b expected %b", tag, act, expv);
    end
    if ((act[3] && act[2]) || (act[1] && act[0])) begin
      failed++;
      $display("FAIL R12: both gates of a leg on, actual %b expected no overlap", act);
    end
  endtask

  function automatic logic [3:0] gates_now();
    return {gate_hi[1], gate_lo[1], gate_hi[0], gate_lo[0]};
  endfunction

  // Apply a new stimulus at a falling edge and follow every cycle of the interval.
  task automatic step(input logic [8:0] s, input string tagx);
    logic [3:0] oldv, newv, blank;
    oldv = expect_gates(cur);
    newv = expect_gates(s);
    cur = s;
    drive(s);
    blank = newv;
    if (oldv[1:0] != newv[1:0]) blank[1:0] = 2'b00;
    if (oldv[3:2] != newv[3:2]) blank[3:2] = 2'b00;
    for (int j = 0; j <= DEAD; j++) begin
      @(negedge clk);
      if (j < DEAD) check((tagx.len() > 0) ? tagx : "R8", gates_now(), (j == 0) ? blank : blank);
      else          check((tagx.len() > 0) ? tagx : tag_of(s), gates_now(), newv);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failed++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    tests = 0; failed = 0; finished = 0;
    cur = 9'h000;
    drive(9'h000);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", gates_now(), 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", gates_now(), 4'b0000);

    // R10: anti-phase, full mode enabled, PWM tied high, DIR toggles
    step(9'b0_00_0_0_1_1_1_1, "");
    step(9'b0_00_0_0_1_1_0_1, "R10");
    step(9'b0_00_0_0_1_1_1_1, "R10");

    // R9: re-change inside the interval restarts it (half mode, leg A)
    step(9'b0_00_0_0_0_1_1_0, "");
    drive(9'b0_00_0_0_0_1_0_0);
    @(negedge clk); check("R9", gates_now(), 4'b0000);
    @(negedge clk); check("R9", gates_now(), 4'b0000);
    drive(9'b0_00_0_0_0_1_1_0);
    cur = 9'b0_00_0_0_0_1_1_0;
    for (int j = 0; j < DEAD; j++) begin
      @(negedge clk); check("R9", gates_now(), 4'b0000);
    end
    @(negedge clk); check("R9", gates_now(), 4'b0010);

    // Near-exhaustive sweeps in two orders
    for (int i = 0; i < 512; i++) step(9'((i * 173) % 512), "");
    for (int i = 0; i < 512; i++) step(9'(i ^ (i >> 1)), "");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule